// File: doc/BRIEF.md
# Paged Write Load Controller

This block is the write side of a byte-wide nonvolatile memory, in clocked form. A host drives active-low chip enable, output enable and write enable, a 15-bit address and an 8-bit data bus. The block samples these pins on the clock. Each completed write strobe becomes one byte load into a 64-slot page buffer, and each slot carries a loaded flag. The first load of a window fixes the page. Later loads to that page can fill any slot, in any order, and may rewrite a slot.

When no accepted load arrives for a set number of cycles, the window closes and `busy` rises. A fixed programming period follows, of standard or fast length chosen by parameter. The block then walks the 64 slots and writes only the flagged ones into the behavioural array. The flags clear at the end and `busy` falls. Reads use the same pins and return array bytes on `dout`.

Top module: `paged_write_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `busy` and `dout` are 0 and no load window is open. The array holds all zeros from time zero.
- R2: A write strobe is active only in sampled cycles with `ce_n`=0, `we_n`=0 and `oe_n`=1. Holding `oe_n` low, `ce_n` high or `we_n` high produces no load.
- R3: A load takes its address from the first sampled cycle of the strobe, which is the later falling edge of the two enables. It takes its data from the last sampled cycle before the strobe ends, which is the first rising edge.
- R4: A load is accepted on the second rising clock edge after the first sample with the strobe inactive. The first load of a window sets the page to address bits [14:6]. Bits [5:0] select the slot, slots may be loaded in any order, and the last write to a slot wins.
- R5: During a window, a load whose address bits [14:6] differ from the page is ignored and does not restart the timeout.
- R6: The window closes `LOAD_TMO_CYC` edges after the edge that accepted the last load. `busy` is 1 from that edge onward. A load accepted on that same edge keeps the window open.
- R7: `busy` stays high for `PROG_CYC + 64` cycles. `PROG_CYC` is `PROG_CYC_FAST` when `FAST_PROG`=1 and `PROG_CYC_STD` otherwise.
- R8: Only flagged slots are written to the array, at index {page, slot} reduced to its low `ARRAY_AW` bits. Every other array byte keeps its value.
- R9: Strobes that complete while `busy` is high are ignored. All slot flags are clear once `busy` falls.
- R10: In a sampled cycle with `ce_n`=0, `oe_n`=0 and `we_n`=1, `dout` shows the array byte at that address after the next rising edge. It shows the value from before any array write on that same edge. Otherwise `dout` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 15 | Byte address: page in [14:6], slot in [5:0] |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data |
| busy | output | 1 | High from window close until commit completes |

## Verification
The assertions assume that the pins change only between clock edges and that each strobe lasts at least one sampled cycle. Under those assumptions, load events can never occur on adjacent cycles. The stimulus drives every pin on the falling clock edge and holds each strobe for two or more cycles. It spaces the loads inside a window below the timeout, except where a test lets the timeout expire on purpose. The assertions also assume that the page register moves only when a window opens, and the stimulus opens at most one window at a time.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_PROG   = 2'd2,
    ST_COMMIT = 2'd3
  } pwl_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pwl_strobe.sv
module pwl_strobe #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              ld_valid,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);
  logic ce_q, oe_q, we_q, on_d;
  logic [ADDR_W-1:0] addr_q, addr_lat;
  logic [DATA_W-1:0] din_q, data_hold;
  logic wr_on;

  assign wr_on   = ~ce_q & ~we_q & oe_q;
  assign rd_en   = ~ce_q & ~oe_q & we_q;
  assign rd_addr = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q      <= 1'b1;
      oe_q      <= 1'b1;
      we_q      <= 1'b1;
      addr_q    <= '0;
      din_q     <= '0;
      on_d      <= 1'b0;
      addr_lat  <= '0;
      data_hold <= '0;
      ld_valid  <= 1'b0;
      ld_addr   <= '0;
      ld_data   <= '0;
    end else begin
      ce_q     <= ce_n;
      oe_q     <= oe_n;
      we_q     <= we_n;
      addr_q   <= addr;
      din_q    <= din;
      on_d     <= wr_on;
      ld_valid <= ~wr_on & on_d;
      if (wr_on && !on_d) addr_lat <= addr_q;
      if (wr_on) data_hold <= din_q;
      if (!wr_on && on_d) begin
        ld_addr <= addr_lat;
        ld_data <= data_hold;
      end
    end
  end
endmodule

// File: rtl/pwl_page_buf.sv
module pwl_page_buf #(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [(1<<SLOT_W)-1:0] valid_mask
);
  localparam int SLOTS = 1 << SLOT_W;

  logic [DATA_W-1:0] slot_data [SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) slot_data[wr_slot] <= wr_data;
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clr) valid_mask[i] <= 1'b0;
      else if (wr_en && wr_slot == SLOT_W'(i)) valid_mask[i] <= 1'b1;
    end
  end

  assign rd_data  = slot_data[rd_slot];
  assign rd_valid = valid_mask[rd_slot];
endmodule

// File: rtl/pwl_seq.sv
module pwl_seq
  import pwl_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int SLOT_W       = 6,
  parameter int LOAD_TMO_CYC = 7500,
  parameter int PROG_CYC     = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              buf_we,
  output logic [SLOT_W-1:0] buf_slot,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_clr,
  output logic [SLOT_W-1:0] cm_slot,
  input  logic [DATA_W-1:0] cm_data,
  input  logic              cm_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [ADDR_W-SLOT_W-1:0] page,
  output pwl_state_e        state,
  output logic              busy
);
  localparam int PAGE_W = ADDR_W - SLOT_W;
  localparam int TW     = $clog2(max_int(LOAD_TMO_CYC, PROG_CYC) + 1);
  localparam logic [TW-1:0] TMO_LAST  = TW'(LOAD_TMO_CYC - 1);
  localparam logic [TW-1:0] PROG_LAST = TW'(PROG_CYC - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = '1;

  logic [TW-1:0]     tmr;
  logic [SLOT_W-1:0] cidx;
  logic [PAGE_W-1:0] ld_page;
  logic              same_page;

  assign ld_page   = ld_addr[ADDR_W-1:SLOT_W];
  assign same_page = (ld_page == page);
  assign buf_we    = ld_valid && (state == ST_IDLE || (state == ST_LOAD && same_page));
  assign buf_slot  = ld_addr[SLOT_W-1:0];
  assign buf_data  = ld_data;
  assign buf_clr   = (state == ST_COMMIT) && (cidx == SLOT_LAST);
  assign cm_slot   = cidx;
  assign mem_we    = (state == ST_COMMIT) && cm_valid;
  assign mem_addr  = {page, cidx};
  assign mem_data  = cm_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      tmr   <= '0;
      cidx  <= '0;
      page  <= '0;
      busy  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ld_valid) begin
            page  <= ld_page;
            tmr   <= '0;
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (ld_valid && same_page) begin
            tmr <= '0;
          end else if (tmr == TMO_LAST) begin
            tmr   <= '0;
            state <= ST_PROG;
            busy  <= 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_PROG: begin
          if (tmr == PROG_LAST) begin
            cidx  <= '0;
            state <= ST_COMMIT;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_COMMIT: begin
          cidx <= cidx + 1'b1;
          if (cidx == SLOT_LAST) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwl_array.sv
module pwl_array #(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int ARRAY_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] dout
);
  localparam int DEPTH = 1 << ARRAY_AW;

  logic [DATA_W-1:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr[ARRAY_AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else if (re) dout <= cells[raddr[ARRAY_AW-1:0]];
  end
endmodule

// File: rtl/paged_write_ctrl.sv
module paged_write_ctrl
  import pwl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int SLOT_W        = 6,
  parameter int ARRAY_AW      = 10,
  parameter int LOAD_TMO_CYC  = 7500,
  parameter int PROG_CYC_STD  = 500000,
  parameter int PROG_CYC_FAST = 150000,
  parameter bit FAST_PROG     = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [14:0]       addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              busy
);
  localparam int PROG_CYC = FAST_PROG ? PROG_CYC_FAST : PROG_CYC_STD;
  localparam int PAGE_W   = ADDR_W - SLOT_W;

  logic              ld_valid_w, rd_en_w;
  logic [ADDR_W-1:0] ld_addr_w, rd_addr_w, mem_addr_w;
  logic [DATA_W-1:0] ld_data_w, buf_data_w, cm_data_w, mem_data_w;
  logic              buf_we_w, buf_clr_w, cm_valid_w, mem_we_w;
  logic [SLOT_W-1:0] buf_slot_w, cm_slot_w;
  logic [(1<<SLOT_W)-1:0] valid_w;
  logic [PAGE_W-1:0] page_w;
  pwl_state_e        state_w;

  pwl_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din),
    .ld_valid(ld_valid_w), .ld_addr(ld_addr_w), .ld_data(ld_data_w),
    .rd_en(rd_en_w), .rd_addr(rd_addr_w)
  );

  pwl_page_buf #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_buf (
    .clk(clk), .rst(rst),
    .wr_en(buf_we_w), .wr_slot(buf_slot_w), .wr_data(buf_data_w),
    .clr(buf_clr_w), .rd_slot(cm_slot_w),
    .rd_data(cm_data_w), .rd_valid(cm_valid_w), .valid_mask(valid_w)
  );

  pwl_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W),
    .LOAD_TMO_CYC(LOAD_TMO_CYC), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid_w), .ld_addr(ld_addr_w), .ld_data(ld_data_w),
    .buf_we(buf_we_w), .buf_slot(buf_slot_w), .buf_data(buf_data_w),
    .buf_clr(buf_clr_w), .cm_slot(cm_slot_w), .cm_data(cm_data_w),
    .cm_valid(cm_valid_w), .mem_we(mem_we_w), .mem_addr(mem_addr_w),
    .mem_data(mem_data_w), .page(page_w), .state(state_w), .busy(busy)
  );

  pwl_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARRAY_AW(ARRAY_AW)) u_array (
    .clk(clk), .rst(rst),
    .we(mem_we_w), .waddr(mem_addr_w), .wdata(mem_data_w),
    .re(rd_en_w), .raddr(rd_addr_w), .dout(dout)
  );
endmodule

// File: rtl/pwl_chk.sv
module pwl_chk
  import pwl_pkg::*;
#(
  parameter int SLOTS  = 64,
  parameter int PAGE_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              ld_valid,
  input logic              buf_we,
  input logic              mem_we,
  input logic [SLOTS-1:0]  valid_mask,
  input logic [PAGE_W-1:0] page,
  input logic [1:0]        state
);
  // R9
  load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> !busy);

  // R8
  commit_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R9
  flags_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (valid_mask == '0));

  // R3
  ld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> !ld_valid);

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD && $past(state) == ST_LOAD) |-> $stable(page));

  // R6
  busy_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(state) == ST_LOAD));
endmodule

bind paged_write_ctrl pwl_chk #(.SLOTS(1 << SLOT_W), .PAGE_W(ADDR_W - SLOT_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .ld_valid(ld_valid_w),
  .buf_we(buf_we_w), .mem_we(mem_we_w), .valid_mask(valid_w),
  .page(page_w), .state(state_w)
);

// File: tb/tb_paged_write_ctrl.sv
module tb_paged_write_ctrl;
  localparam int CLK_P = 10;
  localparam int TMO   = 20;
  localparam int PSTD  = 40;
  localparam int PFAST = 15;
  localparam int PAGE  = 64;
  localparam int AAW   = 10;
  localparam int MASK  = (1 << AAW) - 1;
  localparam int PROG  = PSTD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  paged_write_ctrl #(
    .ARRAY_AW(AAW), .LOAD_TMO_CYC(TMO), .PROG_CYC_STD(PSTD),
    .PROG_CYC_FAST(PFAST), .FAST_PROG(1'b0)
  ) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy)
  );

  always #(CLK_P/2) clk = ~clk;

  // Behavioural reference: timestamps and queues.
  int   cyc = 0;
  bit   win_open;
  int   last_acc;
  int   mpage;
  logic [7:0] mdata [PAGE];
  bit   mvalid [PAGE];
  logic [7:0] mmem [1 << AAW];
  int   q_due[$];
  int   q_addr[$];
  int   q_data[$];
  bit   prev_on, prev_rd;
  int   prev_addr, start_addr, hold_data;
  logic [7:0] exp_dout;
  bit   exp_busy;

  initial begin
    for (int i = 0; i < (1 << AAW); i++) mmem[i] = 8'h00;
    for (int i = 0; i < PAGE; i++) begin mvalid[i] = 0; mdata[i] = 8'h00; end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      win_open = 0; prev_on = 0; prev_rd = 0;
      exp_dout = 8'h00; exp_busy = 0;
      q_due.delete(); q_addr.delete(); q_data.delete();
    end else begin
      bit loading, idle;
      bit cur_on, cur_rd;
      loading = win_open && (cyc <= last_acc + TMO);
      idle    = !win_open;
      if (prev_rd) exp_dout = mmem[prev_addr & MASK];
      if (win_open) begin
        int cb;
        cb = last_acc + TMO + PROG;
        if (cyc > cb && cyc <= cb + PAGE) begin
          int s;
          s = cyc - cb - 1;
          if (mvalid[s]) mmem[(mpage * PAGE + s) & MASK] = mdata[s];
          if (cyc == cb + PAGE) begin
            win_open = 0;
            for (int i = 0; i < PAGE; i++) mvalid[i] = 0;
          end
        end
      end
      while (q_due.size() > 0 && q_due[0] == cyc) begin
        int a, d;
        a = q_addr.pop_front(); d = q_data.pop_front(); void'(q_due.pop_front());
        if (idle) begin
          win_open = 1; mpage = a >> 6; last_acc = cyc;
          for (int i = 0; i < PAGE; i++) mvalid[i] = 0;
          mvalid[a & 63] = 1; mdata[a & 63] = d[7:0];
          idle = 0;
        end else if (loading && (a >> 6) == mpage) begin
          mvalid[a & 63] = 1; mdata[a & 63] = d[7:0]; last_acc = cyc;
        end
      end
      exp_busy = win_open && (cyc >= last_acc + TMO) && (cyc < last_acc + TMO + PROG + PAGE);
      cur_on = !ce_n && !we_n && oe_n;
      cur_rd = !ce_n && !oe_n && we_n;
      if (cur_on && !prev_on) start_addr = int'(addr);
      if (cur_on) hold_data = int'(din);
      if (!cur_on && prev_on) begin
        q_due.push_back(cyc + 2); q_addr.push_back(start_addr); q_data.push_back(hold_data);
      end
      prev_on = cur_on; prev_rd = cur_rd; prev_addr = int'(addr);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (busy !== exp_busy) begin
        errors++;
        $display("FAIL R7 busy at cycle %0d: act %0b exp %0b", cyc, busy, exp_busy);
      end
      checks++;
      if (dout !== exp_dout) begin
        errors++;
        $display("FAIL R10 dout at cycle %0d: act %02h exp %02h", cyc, dout, exp_dout);
      end
    end
  end

  task automatic write_byte(input int a, input int d);
    @(negedge clk);
    addr = 15'(a); din = 8'(d); oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_read(input int a, input int expv, input string tag);
    @(negedge clk);
    addr = 15'(a); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (dout !== 8'(expv)) begin
      errors++;
      $display("FAIL %s read %04h: act %02h exp %02h", tag, a, dout, 8'(expv));
    end
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_done();
    repeat (TMO + PROG + PAGE + 10) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    checks++;
    if (busy !== 1'b0 || dout !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset: busy %0b dout %02h exp 0 00", busy, dout);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (busy !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset busy act %0b exp 0", busy);
    end
    check_read(5, 8'h00, "R1");

    // R8: seed a byte, then a second window that must not disturb it
    write_byte(3*64 + 2, 8'hA2);
    wait_done();
    // R4: out-of-order loads with a slot rewritten
    write_byte(3*64 + 5, 8'h10);
    write_byte(3*64 + 1, 8'h21);
    write_byte(3*64 + 63, 8'h3F);
    write_byte(3*64 + 5, 8'h55);
    wait_done();
    check_read(3*64 + 5, 8'h55, "R4");
    check_read(3*64 + 1, 8'h21, "R4");
    check_read(3*64 + 63, 8'h3F, "R4");
    check_read(3*64 + 2, 8'hA2, "R8");
    check_read(3*64 + 3, 8'h00, "R8");

    // R5: foreign page load ignored
    write_byte(4*64 + 0, 8'h11);
    write_byte(6*64 + 0, 8'h22);
    write_byte(6*64 + 7, 8'h23);
    wait_done();
    check_read(4*64 + 0, 8'h11, "R5");
    check_read(6*64 + 0, 8'h00, "R5");

    // R6: gaps below the timeout keep one window
    write_byte(12*64 + 10, 8'hC1);
    repeat (TMO - 6) @(negedge clk);
    write_byte(12*64 + 11, 8'hC2);
    wait_done();
    check_read(12*64 + 10, 8'hC1, "R6");
    check_read(12*64 + 11, 8'hC2, "R6");

    // R9: strobe during busy ignored
    write_byte(7*64 + 3, 8'h33);
    repeat (TMO + 5) @(negedge clk);
    checks++;
    if (busy !== 1'b1) begin
      errors++;
      $display("FAIL R6 busy act %0b exp 1", busy);
    end
    write_byte(7*64 + 4, 8'h44);
    wait_done();
    check_read(7*64 + 3, 8'h33, "R9");
    check_read(7*64 + 4, 8'h00, "R9");

    // R2: output enable low blocks the write
    @(negedge clk);
    addr = 15'(9*64 + 9); din = 8'hEE; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (TMO + 5) @(negedge clk);
    checks++;
    if (busy !== 1'b0) begin
      errors++;
      $display("FAIL R2 busy act %0b exp 0", busy);
    end
    check_read(9*64 + 9, 8'h00, "R2");

    // R3: address from strobe start, data from last strobe cycle
    @(negedge clk);
    addr = 15'(10*64 + 20); din = 8'h01; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b1;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); addr = 15'(10*64 + 30); din = 8'h5A;
    @(negedge clk); din = 8'h77;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1; din = 8'h99;
    wait_done();
    check_read(10*64 + 20, 8'h77, "R3");
    check_read(10*64 + 30, 8'h00, "R3");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule